// File: doc/BRIEF.md
# Split-Halfword Settings Register Bus

This block sits on a 16-bit memory-mapped peripheral bus and feeds a bank of 64 write-only 32-bit settings registers held by downstream consumers. Software fills one register with two halfword writes: the low half first, then the high half. The low half waits in a single holding register. When the high half arrives, the block emits one strobe cycle. That cycle carries the register index and the full 32-bit value, formed from the high half just written and the low half last held.

The window base is the slave index shifted left by 7 bits. The window spans 64 words (256 bytes), so the slave index must be even. Register n sits at byte offset 4*n. Byte address bit 1 selects the half: 0 is low, 1 is high. The bus carries halfword addresses, so address bit 0 does not exist on the port. Every in-window access is acknowledged in the cycle it is presented, so the bus is never back-pressured. Reads are acknowledged but return nothing and change nothing. The strobe side has no ready signal, and consumers must take each strobe in the cycle it appears.

Top module: `split_settings_bus`

## Requirements
- R1: `bus_ack` is high in the same cycle as `bus_valid` when `bus_addr[15:8]` equals bits [15:8] of the window base (slave index << 7, default 0x400), for reads and writes alike; it is low otherwise.
- R2: An acknowledged write with `bus_addr[1]`=0 stores `bus_wdata` in the low-half holding register and produces no strobe.
- R3: An acknowledged write with `bus_addr[1]`=1 raises `set_stb` in the following cycle, with `set_addr` = {2'b00, `bus_addr[7:2]`} and `set_data` = {`bus_wdata`, held low half}.
- R4: `set_stb` lasts exactly one cycle per high-half write; back-to-back high-half writes produce strobes on consecutive cycles, and no strobe appears without a high-half write.
- R5: An acknowledged read produces no strobe and leaves the holding register unchanged.
- R6: An access outside the window is not acknowledged, produces no strobe and leaves the holding register unchanged.
- R7: A high-half write with no low-half write since reset commits a low half of 0x0000. Otherwise the commit uses the most recent low half, whichever register index that low half was written to.
- R8: While reset is high, `set_stb`, `set_addr`, `set_data` and the holding register are all cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Bus access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 15 | Byte address bits [15:1] |
| bus_wdata | input | 16 | Write halfword |
| bus_ack | output | 1 | Same-cycle acknowledge for in-window accesses |
| set_stb | output | 1 | One-cycle settings write strobe |
| set_addr | output | 8 | Register index, zero-extended |
| set_data | output | 32 | Committed 32-bit value |

## Verification
The main stimulus is a long random mix of low writes, high writes, reads, idle cycles and out-of-window accesses, with data and indices drawn at random. A reference model tracks the held low half. This mix shows whether the held half is updated only by acknowledged low writes, or is also corrupted by reads, stray windows or high writes. Directed cases add four checks. A high write straight after reset shows whether the holding register is truly cleared. A low write at one index followed by a high write at another shows that the index comes from the high write only. Back-to-back high writes separate a one-cycle pulse from a stretched or swallowed one. A read placed between the halves shows whether reads disturb the pairing.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  localparam int HALF_W     = 16;
  localparam int FULL_W     = 2 * HALF_W;
  localparam int STB_ADDR_W = 8;

  typedef struct packed {
    logic                  stb;
    logic [STB_ADDR_W-1:0] addr;
    logic [FULL_W-1:0]     data;
  } settings_wr_t;
endpackage

// File: rtl/sbus_window_decode.sv
module sbus_window_decode #(
  parameter int                ADDR_W  = 16,
  parameter int                IDX_W   = 6,
  parameter logic [ADDR_W-1:0] BASE    = 16'h0400
) (
  input  logic [ADDR_W-1:1] addr,
  output logic              hit,
  output logic              hi_half,
  output logic [IDX_W-1:0]  idx
);
  localparam int WIN_LSB = IDX_W + 2;

  always_comb begin
    hit     = (addr[ADDR_W-1:WIN_LSB] == BASE[ADDR_W-1:WIN_LSB]);
    hi_half = addr[1];
    idx     = addr[WIN_LSB-1:2];
  end
endmodule

// File: rtl/sbus_low_hold.sv
module sbus_low_hold #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (cap_en) q <= din;
  end
endmodule

// File: rtl/sbus_commit.sv
module sbus_commit
  import sbus_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [IDX_W-1:0]  idx,
  input  logic [HALF_W-1:0] hi,
  input  logic [HALF_W-1:0] lo,
  output settings_wr_t      wr
);
  settings_wr_t nxt;

  always_comb begin
    nxt      = wr;
    nxt.stb  = fire;
    if (fire) begin
      nxt.addr = STB_ADDR_W'(idx);
      nxt.data = {hi, lo};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) wr <= '0;
    else     wr <= nxt;
  end
endmodule

// File: rtl/split_settings_bus.sv
module split_settings_bus
  import sbus_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int SLAVE_IDX = 8,
  parameter int REG_CNT   = 64
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_valid,
  input  logic                  bus_write,
  input  logic [ADDR_W-1:1]     bus_addr,
  input  logic [HALF_W-1:0]     bus_wdata,
  output logic                  bus_ack,
  output logic                  set_stb,
  output logic [STB_ADDR_W-1:0] set_addr,
  output logic [FULL_W-1:0]     set_data
);
  localparam int                IDX_W    = $clog2(REG_CNT);
  localparam logic [ADDR_W-1:0] WIN_BASE = ADDR_W'(SLAVE_IDX) << 7;

  logic              hit, hi_half;
  logic [IDX_W-1:0]  idx;
  logic [HALF_W-1:0] low_q;
  logic              wr_lo, wr_hi;
  settings_wr_t      wr;

  sbus_window_decode #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .BASE(WIN_BASE)
  ) u_dec (
    .addr(bus_addr), .hit(hit), .hi_half(hi_half), .idx(idx)
  );

  always_comb begin
    bus_ack = bus_valid & hit;
    wr_lo   = bus_ack & bus_write & ~hi_half;
    wr_hi   = bus_ack & bus_write &  hi_half;
  end

  sbus_low_hold #(.W(HALF_W)) u_hold (
    .clk(clk), .rst(rst), .cap_en(wr_lo), .din(bus_wdata), .q(low_q)
  );

  sbus_commit #(.IDX_W(IDX_W)) u_commit (
    .clk(clk), .rst(rst), .fire(wr_hi), .idx(idx),
    .hi(bus_wdata), .lo(low_q), .wr(wr)
  );

  assign set_stb  = wr.stb;
  assign set_addr = wr.addr;
  assign set_data = wr.data;
endmodule

// File: rtl/sbus_checker.sv
module sbus_checker #(
  parameter int IDX_W  = 6,
  parameter int HALF_W = 16,
  parameter int SA_W   = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_write,
  input logic              hi_sel,
  input logic [IDX_W-1:0]  widx,
  input logic [HALF_W-1:0] bus_wdata,
  input logic              bus_ack,
  input logic              set_stb,
  input logic [SA_W-1:0]   set_addr,
  input logic [HALF_W-1:0] set_hi
);
  AST_ACK_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    bus_ack |-> bus_valid); // R1
  AST_HIGH_FIRES: assert property (@(posedge clk) disable iff (rst)
    (bus_ack && bus_write && hi_sel) |=> set_stb); // R3
  AST_STB_INDEX: assert property (@(posedge clk) disable iff (rst)
    (bus_ack && bus_write && hi_sel) |=> (set_addr == SA_W'($past(widx)))); // R3
  AST_STB_HIGH_HALF: assert property (@(posedge clk) disable iff (rst)
    (bus_ack && bus_write && hi_sel) |=> (set_hi == $past(bus_wdata))); // R3
  AST_STB_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    !(bus_ack && bus_write && hi_sel) |=> !set_stb); // R4
  AST_READ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (bus_ack && !bus_write) |=> !set_stb); // R5
  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (!set_stb && set_addr == '0)); // R8
endmodule

bind split_settings_bus sbus_checker u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .hi_sel(bus_addr[1]), .widx(bus_addr[7:2]), .bus_wdata(bus_wdata),
  .bus_ack(bus_ack), .set_stb(set_stb), .set_addr(set_addr),
  .set_hi(set_data[31:16])
);

// File: tb/tb_split_settings_bus.sv
module tb_split_settings_bus;
  logic        clk = 0;
  logic        rst = 1;
  logic        bus_valid = 0, bus_write = 0;
  logic [15:1] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_ack, set_stb;
  logic [7:0]  set_addr;
  logic [31:0] set_data;

  int n_run = 0, n_fail = 0;
  logic [15:0] m_low = 16'h0000;
  bit done = 0;

  always #10 clk = ~clk;

  split_settings_bus dut (.*);

  function automatic bit in_win(logic [15:0] a);
    return a[15:8] == 8'h04;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // byte address a (bit 0 dropped), called just after a negedge
  task automatic op(bit v, bit w, logic [15:0] a, logic [15:0] d, string req);
    bit          eack, estb;
    logic [31:0] edata;
    logic [7:0]  eaddr;
    bus_valid = v; bus_write = w; bus_addr = a[15:1]; bus_wdata = d;
    eack  = v && in_win(a);
    estb  = eack && w && a[1];
    eaddr = {2'b00, a[7:2]};
    edata = {d, m_low};
    #2;
    chk(bus_ack == eack, {req, " R1 ack"}, 64'(bus_ack), 64'(eack));
    @(posedge clk); #5;
    chk(set_stb == estb, {req, " R4 stb"}, 64'(set_stb), 64'(estb));
    if (estb) begin
      chk(set_addr == eaddr, {req, " R3 addr"}, 64'(set_addr), 64'(eaddr));
      chk(set_data == edata, {req, " R3 data"}, 64'(set_data), 64'(edata));
    end
    if (eack && w && !a[1]) m_low = d;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(set_stb == 0 && set_addr == 0 && set_data == 0, "R8 reset",
        {31'b0, set_stb, set_addr, set_data[23:0]}, 0);
    rst = 0;
    @(negedge clk);
    // R7: high half right after reset commits low 0000
    op(1, 1, 16'h0416, 16'hBEEF, "R7 fresh");
    // R2 low then R3 high
    op(1, 1, 16'h0420, 16'h1234, "R2 low");
    op(1, 1, 16'h0422, 16'h5678, "R3 high");
    // R9-ish cross index: low at 3, high at 9 (R7 most recent low)
    op(1, 1, 16'h040C, 16'hAAAA, "R7 low");
    op(1, 1, 16'h0426, 16'h5555, "R7 cross");
    // R5: read between halves
    op(1, 1, 16'h04FC, 16'h0F0F, "R2 low");
    op(1, 0, 16'h04FC, 16'hDEAD, "R5 read");
    op(1, 0, 16'h04FE, 16'hDEAD, "R5 read hi");
    op(1, 1, 16'h04FE, 16'hF0F0, "R5 high");
    // R6: out-of-window low and high writes
    op(1, 1, 16'h0500, 16'h9999, "R6 stray low");
    op(1, 1, 16'h0302, 16'h9999, "R6 stray high");
    op(1, 1, 16'h0402, 16'h7777, "R6 after");
    // R4 back-to-back highs then idle
    op(1, 1, 16'h0406, 16'h0001, "R4 b2b0");
    op(1, 1, 16'h040A, 16'h0002, "R4 b2b1");
    op(0, 1, 16'h040E, 16'h0003, "R4 idle");
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [15:0] a;
      int sel = $urandom_range(0, 9);
      a = (sel < 8) ? {8'h04, 8'($urandom)} : 16'($urandom);
      a[0] = 1'b0;
      op($urandom_range(0, 5) != 0, $urandom_range(0, 3) != 0, a,
         16'($urandom), "R2 R3 R5 R6 rand");
    end
    // R8: reset mid-stream clears holding register
    op(1, 1, 16'h0400, 16'hCAFE, "R2 pre");
    rst = 1; @(negedge clk); rst = 0; m_low = 16'h0000;
    op(1, 1, 16'h0402, 16'h1111, "R8 hold clr");
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hang expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule